// File: doc/BRIEF.md
# Two-Wire Level-Encoded Word Serial Link

This block moves a parallel word across two wires, one bit per clock step, using two-phase level-encoded dual-rail signalling. A state wire always shows the current bit value. A phase wire changes only when a bit repeats the value before it. Each bit therefore produces exactly one transition on exactly one wire, and the XOR of the two wires flips once per bit. The receiver watches that XOR. Whenever it differs from the parity the receiver last stored, a fresh bit is present, and its value is read off the state wire.

Flow control works per word rather than per bit. After it has collected a full word, the receiver presents it for one cycle and toggles a two-phase acknowledge. That acknowledge passes through a two-flop synchronizer into the sender's domain. The sender accepts no new word until it has seen the toggle. Both halves run from one clock here, and the synchronizer still models the crossing delay.

Transmitter states: `TX_IDLE` (ready for a word), `TX_SHIFT` (one bit placed on the wires per cycle) and `TX_WAIT_ACK` (waiting for the synchronized acknowledge to toggle). Transitions:
- `TX_IDLE` to `TX_SHIFT` when a start is accepted.
- `TX_SHIFT` to `TX_WAIT_ACK` after the last bit.
- `TX_WAIT_ACK` to `TX_IDLE` when the acknowledge toggle is seen.

Receiver states: `RX_HUNT` (no bit of the word yet), `RX_GATHER` (part of the word held) and `RX_EMIT` (word valid, acknowledge toggles). Transitions:
- `RX_HUNT` to `RX_GATHER` on the first bit.
- `RX_GATHER` to `RX_EMIT` on the last bit.
- `RX_EMIT` to `RX_HUNT` unconditionally.

Top module: `ledr_serial_link`

## Requirements
- R1: After reset, both wires are 0, `tx_ready` is 1 and `rx_valid` is 0.
- R2: Each transmitted bit causes exactly one transition on exactly one of the two wires. A word of WIDTH bits causes exactly WIDTH transitions, and no cycle ever shows both wires changing.
- R3: The word is sent MSB first. `line_state` equals the bit being sent. `line_phase` toggles only when that bit equals the previous one, so the first bit's value appears on `line_state` one cycle after the start is accepted.
- R4: `rx_word` equals the word that was sent whenever `rx_valid` is 1, and words arrive in the order they were sent.
- R5: `rx_valid` rises exactly WIDTH+1 clock edges after the edge that accepts `tx_start`.
- R6: The receiver toggles one acknowledge per word. It goes through a two-flop synchronizer, so `tx_ready` is still 0 at edge WIDTH+4 after acceptance and returns to 1 at edge WIDTH+5.
- R7: `tx_start` and `tx_word` are ignored while `tx_ready` is 0. No extra word is sent and the word in flight is not changed.
- R8: `rx_valid` is a single-cycle pulse for each word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for sender, receiver and synchronizer |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_start | input | 1 | Request to send `tx_word`; taken when `tx_ready` is 1 |
| tx_word | input | WIDTH | Parallel word to send |
| tx_ready | output | 1 | Sender idle and able to accept a word |
| line_state | output | 1 | State wire (carries the bit value) |
| line_phase | output | 1 | Phase wire (toggles on repeated bit values) |
| rx_word | output | WIDTH | Reassembled word |
| rx_valid | output | 1 | One-cycle strobe marking `rx_word` valid |

## Verification
If the sender's phase logic goes wrong, a wire shows two transitions in one step, or none. The receiver's parity then drifts, and the error shows at the ports within one word: a wrong `rx_word`, a missing `rx_valid`, or a transition count other than WIDTH. A stuck or extra acknowledge toggle shows up as `tx_ready` returning at the wrong edge, or as a lock-up, within WIDTH+5 cycles of the start. A wrong bit order or a wrong bit count shows at the next `rx_valid`, either as a changed word or as a strobe on the wrong cycle.

// File: rtl/ledr_pkg.sv
package ledr_pkg;

    typedef enum logic [1:0] {
        TX_IDLE     = 2'd0,
        TX_SHIFT    = 2'd1,
        TX_WAIT_ACK = 2'd2
    } tx_state_t;

    typedef enum logic [1:0] {
        RX_HUNT   = 2'd0,
        RX_GATHER = 2'd1,
        RX_EMIT   = 2'd2
    } rx_state_t;

endpackage

// File: rtl/ledr_ack_sync.sv
module ledr_ack_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= async_in;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], async_in};
            end
        end
    endgenerate

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/ledr_tx.sv
module ledr_tx
    import ledr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [WIDTH-1:0] word,
    input  logic             ack_sync,
    output logic             ready,
    output logic             wire_s,
    output logic             wire_p
);
    localparam int CW = $clog2(WIDTH + 1);
    localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

    tx_state_t        state_q, state_d;
    logic [WIDTH-1:0] shreg_q;
    logic [CW-1:0]    cnt_q;
    logic             ack_seen_q;
    logic             s_q, p_q;
    logic             cur_bit;

    assign cur_bit = shreg_q[WIDTH-1];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TX_IDLE;
        else        state_q <= state_d;
    end

    // next state and outputs
    always_comb begin
        state_d = state_q;
        ready   = 1'b0;
        unique case (state_q)
            TX_IDLE: begin
                ready = 1'b1;
                if (start) state_d = TX_SHIFT;
            end
            TX_SHIFT: begin
                if (cnt_q == LAST) state_d = TX_WAIT_ACK;
            end
            TX_WAIT_ACK: begin
                if (ack_sync != ack_seen_q) state_d = TX_IDLE;
            end
            default: state_d = TX_IDLE;
        endcase
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q    <= '0;
            cnt_q      <= '0;
            ack_seen_q <= 1'b0;
            s_q        <= 1'b0;
            p_q        <= 1'b0;
        end else begin
            unique case (state_q)
                TX_IDLE: begin
                    if (start) begin
                        shreg_q <= word;
                        cnt_q   <= '0;
                    end
                end
                TX_SHIFT: begin
                    s_q     <= cur_bit;
                    if (cur_bit == s_q) p_q <= ~p_q;
                    shreg_q <= {shreg_q[WIDTH-2:0], 1'b0};
                    cnt_q   <= cnt_q + 1'b1;
                end
                TX_WAIT_ACK: begin
                    if (ack_sync != ack_seen_q) ack_seen_q <= ack_sync;
                end
                default: ;
            endcase
        end
    end

    assign wire_s = s_q;
    assign wire_p = p_q;

    // R2: a shift step moves exactly one wire
    p_one_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TX_SHIFT) |=> ($countones({s_q, p_q} ^ $past({s_q, p_q})) == 1));

    // R2: wires stay quiet outside shifting
    p_quiet_wires_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != TX_SHIFT) |=> ($stable(s_q) && $stable(p_q)));

    // R7: a word in flight is not reloaded
    p_no_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TX_SHIFT && start) |=> (state_q != TX_IDLE));

    // R6: sender leaves the wait only on an acknowledge change
    p_wait_on_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TX_WAIT_ACK && ack_sync == ack_seen_q) |=> (state_q == TX_WAIT_ACK));
endmodule

// File: rtl/ledr_rx.sv
module ledr_rx
    import ledr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wire_s,
    input  logic             wire_p,
    output logic [WIDTH-1:0] word,
    output logic             valid,
    output logic             ack
);
    localparam int CW = $clog2(WIDTH + 1);
    localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

    rx_state_t        state_q, state_d;
    logic             par_q;
    logic [WIDTH-1:0] asm_q;
    logic [WIDTH-1:0] word_q;
    logic [CW-1:0]    cnt_q;
    logic             ack_q;
    logic             fresh;

    assign fresh = ((wire_s ^ wire_p) != par_q);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RX_HUNT;
        else        state_q <= state_d;
    end

    // next state and outputs
    always_comb begin
        state_d = state_q;
        valid   = 1'b0;
        unique case (state_q)
            RX_HUNT: begin
                if (fresh) state_d = RX_GATHER;
            end
            RX_GATHER: begin
                if (fresh && cnt_q == LAST) state_d = RX_EMIT;
            end
            RX_EMIT: begin
                valid   = 1'b1;
                state_d = RX_HUNT;
            end
            default: state_d = RX_HUNT;
        endcase
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            par_q  <= 1'b0;
            asm_q  <= '0;
            word_q <= '0;
            cnt_q  <= '0;
            ack_q  <= 1'b0;
        end else begin
            if (fresh) begin
                par_q <= wire_s ^ wire_p;
                asm_q <= {asm_q[WIDTH-2:0], wire_s};
                if (cnt_q == LAST) begin
                    cnt_q  <= '0;
                    word_q <= {asm_q[WIDTH-2:0], wire_s};
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
            if (state_q == RX_EMIT) ack_q <= ~ack_q;
        end
    end

    assign word = word_q;
    assign ack  = ack_q;

    // R8: strobe lasts a single cycle
    p_valid_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);

    // R6: acknowledge changes only right after a delivered word
    p_ack_per_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_q != $past(ack_q)) |-> $past(valid));

    // R4: delivered word is held while no bit arrives
    p_word_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !fresh) |=> $stable(word_q));
endmodule

// File: rtl/ledr_serial_link.sv
module ledr_serial_link #(
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_start,
    input  logic [WIDTH-1:0] tx_word,
    output logic             tx_ready,
    output logic             line_state,
    output logic             line_phase,
    output logic [WIDTH-1:0] rx_word,
    output logic             rx_valid
);
    logic ack_rx;
    logic ack_tx;

    ledr_tx #(.WIDTH(WIDTH)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (tx_start),
        .word     (tx_word),
        .ack_sync (ack_tx),
        .ready    (tx_ready),
        .wire_s   (line_state),
        .wire_p   (line_phase)
    );

    ledr_rx #(.WIDTH(WIDTH)) u_rx (
        .clk    (clk),
        .rst_n  (rst_n),
        .wire_s (line_state),
        .wire_p (line_phase),
        .word   (rx_word),
        .valid  (rx_valid),
        .ack    (ack_rx)
    );

    ledr_ack_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (ack_rx),
        .sync_out (ack_tx)
    );
endmodule

// File: tb/ledr_serial_link_test.sv
module ledr_serial_link_test;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tx_start = 1'b0;
    logic [W-1:0] tx_word = '0;
    logic         tx_ready, line_state, line_phase, rx_valid;
    logic [W-1:0] rx_word;

    int total = 0;
    int bad = 0;
    int trans_count = 0;
    int received = 0;
    logic [W-1:0] exp_q[$];
    logic prev_s = 1'b0, prev_p = 1'b0;

    always #2 clk = ~clk;

    ledr_serial_link #(.WIDTH(W)) uut (
        .clk(clk), .rst_n(rst_n), .tx_start(tx_start), .tx_word(tx_word),
        .tx_ready(tx_ready), .line_state(line_state), .line_phase(line_phase),
        .rx_word(rx_word), .rx_valid(rx_valid)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // wire monitor (R2)
    always @(negedge clk) begin
        if (rst_n) begin
            int ch;
            ch = int'(line_state != prev_s) + int'(line_phase != prev_p);
            if (ch > 1) check(1'b0, "R2 double edge", ch, 1);
            trans_count += ch;
        end
        prev_s = line_state;
        prev_p = line_phase;
    end

    // scoreboard monitor (R4)
    always @(negedge clk) begin
        if (rst_n && rx_valid) begin
            received++;
            if (exp_q.size() == 0) begin
                check(1'b0, "R4/R7 unexpected word", int'(rx_word), 0);
            end else begin
                logic [W-1:0] e;
                e = exp_q.pop_front();
                check(rx_word == e, "R4 word", int'(rx_word), int'(e));
            end
        end
    end

    task automatic send(input logic [W-1:0] w, input bit poke);
        int t0;
        @(negedge clk);
        while (!tx_ready) @(negedge clk);
        tx_start = 1'b1;
        tx_word  = w;
        exp_q.push_back(w);
        @(posedge clk);
        t0 = trans_count;
        @(negedge clk);
        tx_start = 1'b0;
        tx_word  = '0;
        for (int k = 1; k <= W + 5; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (k == 1) check(line_state == w[W-1], "R3 msb first", int'(line_state), int'(w[W-1]));
            if (poke && k == 3) begin tx_start = 1'b1; tx_word = ~w; end
            if (poke && k == 6) begin tx_start = 1'b0; tx_word = '0; end
            if (k == W)     check(rx_valid == 1'b0, "R5 early valid", int'(rx_valid), 0);
            if (k == W + 1) check(rx_valid == 1'b1, "R5 valid timing", int'(rx_valid), 1);
            if (k == W + 2) check(rx_valid == 1'b0, "R8 single pulse", int'(rx_valid), 0);
            if (k == W + 4) check(tx_ready == 1'b0, "R6 ack sync delay", int'(tx_ready), 0);
            if (k == W + 5) begin
                check(tx_ready == 1'b1, "R6 ready return", int'(tx_ready), 1);
                check(trans_count - t0 == W, "R2 edges per word", trans_count - t0, W);
            end
        end
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(line_state == 1'b0 && line_phase == 1'b0, "R1 wires", int'({line_state, line_phase}), 0);
        check(tx_ready == 1'b1, "R1 ready", int'(tx_ready), 1);
        check(rx_valid == 1'b0, "R1 valid", int'(rx_valid), 0);
        rst_n = 1'b1;
        send(8'h00, 1'b0);
        send(8'hFF, 1'b0);
        send(8'hAA, 1'b0);
        send(8'h55, 1'b1); // R7 poke while busy
        send(8'h80, 1'b0);
        send(8'h01, 1'b1); // R7 poke while busy
        send(8'hC3, 1'b0);
        send(8'h3C, 1'b0);
        repeat (10) @(negedge clk);
        check(exp_q.size() == 0, "R4 all delivered", exp_q.size(), 0);
        check(received == 8, "R7 word count", received, 8);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule